// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns a parallel byte into an asynchronous serial frame on a single output line. The frame shape comes from a 3-bit format code and a separate multiprocessor-mode enable. The code picks 7 or 8 data bits, 1 or 2 stop bits, and whether a parity bit is added. With multiprocessor mode on, a flag bit driven by software takes the place of parity. The bit rate comes from an external one-cycle tick. Each transmitted bit stays on the line for exactly one tick period.

A one-entry holding buffer sits in front of the shift register. Software can load the next byte while the current frame is still going out, and back-to-back frames then leave no idle gap between them. The format code, mode, flag value and parity sense are captured together with the byte when it is loaded. Changes to those inputs afterwards do not affect a frame already accepted.

Top module: `txf_serial_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `busy` is 0, `buf_empty` is 1, and the stored multiprocessor-mode setting is 0.
- R2: A buffered byte starts its frame on the next `bit_tick`. The start bit is 0. Every bit of the frame stays on `tx_line` from one `bit_tick` to the next.
- R3: Data bits are sent least significant bit first. With `fmt` bit 2 equal to 0, only `wdata[6:0]` is sent. With `fmt` bit 2 equal to 1, `wdata[7:0]` is sent.
- R4: `fmt` bit 0 equal to 0 gives one stop bit and 1 gives two. Stop bits are 1, and the line returns to 1 when idle.
- R5: With `fmt` bit 1 equal to 1 and `mp_mode` 0, a parity bit follows the data. It is even parity when `par_odd` is 0 and odd parity when `par_odd` is 1, and it covers only the 7 or 8 data bits actually sent.
- R6: With `mp_mode` 1, exactly one flag bit equal to `mp_flag` follows the data, whatever the value of `fmt` bit 1. No parity bit is sent.
- R7: `wdata`, `fmt`, `mp_mode`, `mp_flag` and `par_odd` are captured when `wr_en` is accepted. Later changes to them do not alter that frame.
- R8: `buf_empty` is 1 exactly when the holding buffer can accept a byte. A byte can be loaded while a frame is shifting. A queued byte begins on the tick that follows the previous frame's last stop bit. `wr_en` is ignored while the buffer is full.
- R9: `busy` is 1 from the start bit through the last stop bit and falls on the first tick after the frame when nothing is queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe for the holding buffer |
| wdata | input | 8 | Byte to transmit |
| fmt | input | 3 | Format code: bit 2 data length, bit 1 parity enable, bit 0 stop length |
| mp_mode | input | 1 | Multiprocessor frame format enable |
| mp_flag | input | 1 | Value of the multiprocessor flag bit |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| bit_tick | input | 1 | One-cycle bit-rate tick |
| tx_line | output | 1 | Serial output line |
| busy | output | 1 | A frame is on the line |
| buf_empty | output | 1 | Holding buffer can accept a byte |

## Verification
Frames are sent in five shapes: 8-bit data with no extra bit, 7-bit even parity with two stops, 8-bit odd parity, and multiprocessor frames with the flag at 1 and at 0. Together these separate the data-length, stop-length and extra-bit fields from one another. A 7-bit frame carrying a byte with bit 7 set shows whether bit 7 leaks onto the line or into the parity. A multiprocessor frame with format bit 1 set shows whether parity wrongly takes the flag's place. Changing every input between load and first tick checks that the settings are captured at load. A back-to-back pair followed by a refused third load checks the gapless hand-over and that a write to a full buffer is dropped.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int unsigned TXF_DATA_W  = 8;
    localparam int unsigned TXF_STOP_MX = 2;
    localparam int unsigned TXF_FRAME_W = 1 + TXF_DATA_W + 1 + TXF_STOP_MX;
    localparam int unsigned TXF_CNT_W   = $clog2(TXF_FRAME_W + 1);

    typedef struct packed {
        logic [2:0] fmt;
        logic       mp_mode;
        logic       mp_flag;
        logic       par_odd;
    } txf_cfg_t;

    typedef struct packed {
        logic [TXF_DATA_W-1:0] data;
        txf_cfg_t              cfg;
    } txf_entry_t;

endpackage

// File: rtl/txf_hold_buf.sv
module txf_hold_buf
    import txf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  txf_entry_t wr_entry,
    input  logic       take,
    output logic       valid,
    output txf_entry_t entry
);

    typedef struct packed {
        logic       valid;
        txf_entry_t entry;
    } hb_state_t;

    hb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.valid = 1'b0;
        end
        if (wr_en && !st_q.valid) begin
            st_d.valid = 1'b1;
            st_d.entry = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign entry = st_q.entry;

    // R8: a write to a full buffer leaves the stored byte untouched
    assert_ignore_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && wr_en && !take) |=> $stable(st_q.entry));

    // R8: the shifter only drains a filled buffer
    assert_take_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> st_q.valid);

endmodule

// File: rtl/txf_frame_build.sv
module txf_frame_build
    import txf_pkg::*;
(
    input  txf_entry_t                 entry,
    output logic [TXF_FRAME_W-1:0]     bits,
    output logic [TXF_CNT_W-1:0]       len
);

    logic [TXF_FRAME_W-1:0] dpad;
    int unsigned            dlen;
    int unsigned            nstop;
    logic                   has_extra;
    logic                   par;
    logic                   extra;

    always_comb begin
        dpad      = TXF_FRAME_W'(entry.data);
        dlen      = entry.cfg.fmt[2] ? TXF_DATA_W : TXF_DATA_W - 1;
        nstop     = entry.cfg.fmt[0] ? 2 : 1;
        has_extra = entry.cfg.mp_mode | entry.cfg.fmt[1];

        par = entry.cfg.par_odd;
        for (int i = 0; i < int'(TXF_DATA_W); i++) begin
            if (i < int'(dlen)) begin
                par = par ^ entry.data[i];
            end
        end
        extra = entry.cfg.mp_mode ? entry.cfg.mp_flag : par;

        bits    = '1;
        bits[0] = 1'b0;
        for (int p = 1; p < int'(TXF_FRAME_W); p++) begin
            if (p <= int'(dlen)) begin
                bits[p] = dpad[p-1];
            end else if (p == int'(dlen) + 1 && has_extra) begin
                bits[p] = extra;
            end
        end

        len = TXF_CNT_W'(1 + dlen + (has_extra ? 1 : 0) + nstop);
    end

endmodule

// File: rtl/txf_shifter.sv
module txf_shifter
    import txf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_tick,
    input  logic                   avail,
    input  logic [TXF_FRAME_W-1:0] frame,
    input  logic [TXF_CNT_W-1:0]   frame_len,
    output logic                   take,
    output logic                   tx_line,
    output logic                   busy
);

    typedef struct packed {
        logic                   busy;
        logic [TXF_FRAME_W-1:0] sh;
        logic [TXF_CNT_W-1:0]   cnt;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (bit_tick) begin
            if (!st_q.busy || st_q.cnt == TXF_CNT_W'(1)) begin
                if (avail) begin
                    take      = 1'b1;
                    st_d.busy = 1'b1;
                    st_d.sh   = frame;
                    st_d.cnt  = frame_len;
                end else begin
                    st_d.busy = 1'b0;
                    st_d.sh   = '1;
                    st_d.cnt  = '0;
                end
            end else begin
                st_d.sh  = {1'b1, st_q.sh[TXF_FRAME_W-1:1]};
                st_d.cnt = st_q.cnt - TXF_CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.sh   <= '1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign tx_line = st_q.busy ? st_q.sh[0] : 1'b1;

    // R2: every new frame opens with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && take) |=> !tx_line);

    // R2: between ticks the line holds its bit
    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && busy) |=> $stable(tx_line));

    // R4: the final bit of any frame is a high stop bit
    assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == TXF_CNT_W'(1)) |-> tx_line);

    // R9: the remaining-bit count stays in range while busy
    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt != '0 && st_q.cnt <= TXF_CNT_W'(TXF_FRAME_W)));

endmodule

// File: rtl/txf_serial_tx.sv
module txf_serial_tx
    import txf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TXF_DATA_W-1:0] wdata,
    input  logic [2:0]            fmt,
    input  logic                  mp_mode,
    input  logic                  mp_flag,
    input  logic                  par_odd,
    input  logic                  bit_tick,
    output logic                  tx_line,
    output logic                  busy,
    output logic                  buf_empty
);

    txf_entry_t             wr_entry;
    txf_entry_t             held;
    logic                   held_valid;
    logic                   take;
    logic [TXF_FRAME_W-1:0] frame;
    logic [TXF_CNT_W-1:0]   frame_len;

    assign wr_entry.data        = wdata;
    assign wr_entry.cfg.fmt     = fmt;
    assign wr_entry.cfg.mp_mode = mp_mode;
    assign wr_entry.cfg.mp_flag = mp_flag;
    assign wr_entry.cfg.par_odd = par_odd;

    txf_hold_buf u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .take     (take),
        .valid    (held_valid),
        .entry    (held)
    );

    txf_frame_build u_build (
        .entry (held),
        .bits  (frame),
        .len   (frame_len)
    );

    txf_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .avail     (held_valid),
        .frame     (frame),
        .frame_len (frame_len),
        .take      (take),
        .tx_line   (tx_line),
        .busy      (busy)
    );

    assign buf_empty = !held_valid;

    // R6: a multiprocessor frame is never longer than start+data+flag+stops
    assert_mp_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held_valid && held.cfg.mp_mode) |->
            (frame_len == TXF_CNT_W'(2 + (held.cfg.fmt[2] ? TXF_DATA_W : TXF_DATA_W - 1)
                                        + (held.cfg.fmt[0] ? 2 : 1))));

    // R4: the line is high whenever no frame is active
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> tx_line);

endmodule

// File: tb/txf_serial_tx_bench.sv
`timescale 1ns/1ps
module txf_serial_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [2:0] fmt = '0;
    logic       mp_mode = 1'b0;
    logic       mp_flag = 1'b0;
    logic       par_odd = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_line, busy, buf_empty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    txf_serial_tx u_txf_serial_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .fmt(fmt),
        .mp_mode(mp_mode), .mp_flag(mp_flag), .par_odd(par_odd),
        .bit_tick(bit_tick), .tx_line(tx_line), .busy(busy), .buf_empty(buf_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void expect_frame(input logic [7:0] d, input logic [2:0] f,
                                         input logic mp, input logic mpb, input logic odd,
                                         output logic [31:0] b, output int n);
        int dl = f[2] ? 8 : 7;
        logic p = odd;
        b = '1;
        b[0] = 1'b0;
        n = 1;
        for (int i = 0; i < dl; i++) begin
            b[n] = d[i];
            p = p ^ d[i];
            n++;
        end
        if (mp) begin
            b[n] = mpb;
            n++;
        end else if (f[1]) begin
            b[n] = p;
            n++;
        end
        n += f[0] ? 2 : 1;
    endfunction

    task automatic load(input logic [7:0] d, input logic [2:0] f,
                        input logic mp, input logic mpb, input logic odd);
        @(negedge clk);
        wr_en = 1'b1; wdata = d; fmt = f; mp_mode = mp; mp_flag = mpb; par_odd = odd;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic grab(input int n, output logic [31:0] bits,
                        output logic all_busy, output logic held);
        bits = '1; all_busy = 1'b1; held = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick_once();
            bits[i] = tx_line;
            all_busy &= busy;
            repeat (2) begin
                @(negedge clk);
                if (tx_line !== bits[i]) held = 1'b0;
            end
        end
    endtask

    task automatic send_one(input logic [7:0] d, input logic [2:0] f, input logic mp,
                            input logic mpb, input logic odd, input bit disturb,
                            input string req);
        logic [31:0] exp_b, got, mask;
        logic all_busy, held;
        int n;
        expect_frame(d, f, mp, mpb, odd, exp_b, n);
        load(d, f, mp, mpb, odd);
        chk(buf_empty == 1'b0, "R8", "buffer full after load", buf_empty, 0);
        if (disturb) begin
            wdata = ~d; fmt = ~f; mp_mode = ~mp; mp_flag = ~mpb; par_odd = ~odd;
        end
        grab(n, got, all_busy, held);
        mask = (32'h1 << n) - 1;
        chk((got & mask) == (exp_b & mask), req, "frame bits", got & mask, exp_b & mask);
        chk(all_busy, "R9", "busy during frame", all_busy, 1);
        chk(held, "R2", "bit held between ticks", held, 1);
        tick_once();
        chk(tx_line == 1'b1 && busy == 1'b0, "R9", "idle after frame",
            {tx_line, busy}, 2'b10);
        chk(buf_empty == 1'b1, "R8", "buffer empty when idle", buf_empty, 1);
    endtask

    task automatic test_reset();
        chk(tx_line == 1'b1 && busy == 1'b0 && buf_empty == 1'b1, "R1", "reset outputs",
            {tx_line, busy, buf_empty}, 3'b101);
        tick_once();
        chk(tx_line == 1'b1 && busy == 1'b0, "R1", "tick with empty buffer",
            {tx_line, busy}, 2'b10);
    endtask

    task automatic test_back_to_back();
        logic [31:0] ea, eb, rest, got, exp_all, mask;
        logic all_busy, held, first;
        int na, nb;
        expect_frame(8'hA5, 3'b100, 1'b0, 1'b0, 1'b0, ea, na);
        expect_frame(8'h5A, 3'b000, 1'b0, 1'b0, 1'b0, eb, nb);
        load(8'hA5, 3'b100, 1'b0, 1'b0, 1'b0);
        tick_once();
        first = tx_line;
        chk(buf_empty == 1'b1 && busy == 1'b1, "R8", "buffer freed at frame start",
            {buf_empty, busy}, 2'b11);
        load(8'h5A, 3'b000, 1'b0, 1'b0, 1'b0);
        chk(buf_empty == 1'b0, "R8", "load accepted while shifting", buf_empty, 0);
        load(8'hFF, 3'b100, 1'b0, 1'b0, 1'b0);
        grab(na + nb - 1, rest, all_busy, held);
        got = {rest[30:0], first};
        exp_all = ea | (eb << na);
        exp_all = (ea & ((32'h1 << na) - 1)) | (eb << na);
        mask = (32'h1 << (na + nb)) - 1;
        chk((got & mask) == (exp_all & mask), "R8", "gapless pair",
            got & mask, exp_all & mask);
        chk(all_busy, "R9", "busy across pair", all_busy, 1);
        tick_once();
        chk(tx_line == 1'b1 && busy == 1'b0 && buf_empty == 1'b1, "R8",
            "third write dropped", {tx_line, busy, buf_empty}, 3'b101);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        send_one(8'hB6, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        send_one(8'hC3, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        send_one(8'h71, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        send_one(8'h0F, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        send_one(8'h55, 3'b010, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
        send_one(8'h81, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        send_one(8'h3C, 3'b100, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
        test_back_to_back();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule